// File: doc/BRIEF.md
# Shared-Pin Serial Register Loader

This block is the configuration front end of an imaging sensor signal processor whose 8-bit pixel output bus doubles as a three-wire serial write port. While the line-sync input is low, the block drives the pixel word onto the bus pads. While line-sync is high, it releases the pads, and three of the pad lines become inputs: bus bit 7 is the load strobe, bit 5 is the serial clock and bit 6 is the serial data.

A host writes a register by pulling load low and clocking in an 11-bit word, most significant bit first. The first three bits are a register address and the remaining eight bits are the payload. The host then raises load to commit the word. The pad lines are brought into the core clock domain through a synchronizer, and every edge is detected on the core clock. The serial clock must therefore be much slower than the core clock.

There are eight decoded registers: a gain and an offset for each of the three colour channels, a mode register and a mode/test register. Their contents appear directly on output ports. The mode register carries a self-clearing soft reset bit and a power-down bit. Leaving power-down invalidates the signal-configuration field.

Top module: `shared_pin_reg_loader`

## Requirements
- R1: While `sync_i` is high, `pad_oe` is 0. While `sync_i` is low, `pad_oe` is 1 and `pad_out` equals `pix_data_i`.
- R2: After reset, every gain reads 0, every offset reads 8'h40, and both `mode_o` and `test_o` read 8'h00.
- R3: A frame starts on a falling edge of load (`pad_in[7]`) while sync is high. On each rising edge of the serial clock (`pad_in[5]`), one bit of `pad_in[6]` is shifted in, MSB first. On the rising edge of load, the 11-bit word {addr[2:0], data[7:0]} is committed.
- R4: If load rises after fewer than 11 serial-clock rises, no register changes.
- R5: Serial-clock rises after the eleventh within a frame are ignored, so only the first 11 bits are written.
- R6: Address decode is 0 red gain, 1 red offset, 2 green gain, 3 green offset, 4 blue gain, 5 blue offset, 6 mode, 7 mode/test. A gain register keeps payload bits 7..2 only.
- R7: A mode write with payload bit 6 set returns all eight registers to their reset values, including the mode register itself. Bit 6 of `mode_o` always reads 0.
- R8: Mode bit 7 is power-down, and mode bits 1..0 are the signal configuration. A mode write that clears bit 7 while it was set stores 00 in bits 1..0, whatever payload bits 1..0 were. Power-down changes no other register, and a later mode write sets bits 1..0 normally.
- R9: If sync falls during a frame, the frame is abandoned, and a following rise of load commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Line sync; high selects serial-port use of the pads |
| pix_data_i | input | 8 | Pixel word to drive onto the pads |
| pad_in | input | 8 | Pad input values (bit 7 load, bit 6 data, bit 5 serial clock) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 1 | Pad output enable |
| gain_red | output | 6 | Red gain code |
| gain_grn | output | 6 | Green gain code |
| gain_blu | output | 6 | Blue gain code |
| offs_red | output | 8 | Red offset code |
| offs_grn | output | 8 | Green offset code |
| offs_blu | output | 8 | Blue offset code |
| mode_o | output | 8 | Mode register |
| test_o | output | 8 | Mode/test register |

## Verification
The bench builds the block with its default parameters: a two-stage pad synchronizer, an 8-bit bus and the fixed 3+8 frame. Each serial-clock phase is held for several core cycles, so that every edge passes the synchronizer. With this setup, frames of 9, 10, 11 and 14 clocks can be sent on demand. The power-down entry and exit sequence, the soft reset and a frame cut off by a sync drop can all be reached at the ports in a few hundred cycles.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int GAIN_W  = 6;
  localparam int NUM_CH  = 3;
  localparam int CFG_W   = 2;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_TEST = 3'd7;

  localparam int MB_PD   = 7;
  localparam int MB_SRST = 6;

  localparam logic [DATA_W-1:0] OFFS_RST = 8'h40;
  localparam logic [DATA_W-1:0] MODE_RST = 8'h00;
  localparam logic [DATA_W-1:0] TEST_RST = 8'h00;
  localparam logic [GAIN_W-1:0] GAIN_RST = '0;
endpackage

// File: rtl/slp_pad_mux.sv
module slp_pad_mux #(
  parameter int BUS_W = 8
) (
  input  logic             sync_i,
  input  logic [BUS_W-1:0] pix_i,
  output logic [BUS_W-1:0] pad_out_o,
  output logic             pad_oe_o
);
  always_comb begin
    pad_oe_o  = ~sync_i;
    pad_out_o = pix_i;
  end
endmodule

// File: rtl/slp_serial_rx.sv
module slp_serial_rx
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               ld_pin,
  input  logic               sc_pin,
  input  logic               sd_pin,
  output logic               commit_o,
  output logic [FRAME_W-1:0] word_o,
  output logic [CNT_W-1:0]   bitcnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] ld_s, sc_s, sd_s;
  logic ld_prev, sc_prev;
  logic ld_now, sc_now, sd_now;
  logic ld_fall, ld_rise, sc_rise;

  logic               armed_q, armed_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               commit_q, commit_d;
  logic [FRAME_W-1:0] word_q, word_d;

  // pad synchronizers; load idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_s    <= '1;
      sc_s    <= '0;
      sd_s    <= '0;
      ld_prev <= 1'b1;
      sc_prev <= 1'b0;
    end else begin
      ld_s    <= {ld_s[SYNC_STAGES-2:0], ld_pin};
      sc_s    <= {sc_s[SYNC_STAGES-2:0], sc_pin};
      sd_s    <= {sd_s[SYNC_STAGES-2:0], sd_pin};
      ld_prev <= ld_now;
      sc_prev <= sc_now;
    end
  end

  always_comb begin
    ld_now  = ld_s[SYNC_STAGES-1];
    sc_now  = sc_s[SYNC_STAGES-1];
    sd_now  = sd_s[SYNC_STAGES-1];
    ld_fall = ld_prev & ~ld_now;
    ld_rise = ~ld_prev & ld_now;
    sc_rise = ~sc_prev & sc_now;
  end

  // frame next-state
  always_comb begin
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    commit_d = 1'b0;
    word_d   = word_q;
    if (!port_en) begin
      armed_d = 1'b0;
    end else if (ld_fall) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && ld_rise) begin
      armed_d = 1'b0;
      if (cnt_q == FULL) begin
        commit_d = 1'b1;
        word_d   = sh_q;
      end
    end else if (armed_q && sc_rise && (cnt_q < FULL)) begin
      sh_d  = {sh_q[FRAME_W-2:0], sd_now};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      armed_q  <= armed_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      commit_q <= commit_d;
      word_q   <= word_d;
    end
  end

  assign commit_o = commit_q;
  assign word_o   = word_q;
  assign bitcnt_o = cnt_q;
endmodule

// File: rtl/slp_reg_bank.sv
module slp_reg_bank
  import slp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           commit_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              data_i,
  output logic [NUM_CH-1:0][GAIN_W-1:0]  gain_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  offs_o,
  output logic [DATA_W-1:0]              mode_o,
  output logic [DATA_W-1:0]              test_o
);
  logic soft_rst;
  logic mode_we, test_we;
  logic [DATA_W-1:0] mode_q, mode_d;
  logic [DATA_W-1:0] test_q;

  always_comb begin
    soft_rst = commit_i && (addr_i == ADR_MODE) && data_i[MB_SRST];
    mode_we  = commit_i && (addr_i == ADR_MODE);
    test_we  = commit_i && (addr_i == ADR_TEST);
  end

  // per-channel gain and offset registers
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADR_G = ADDR_W'(2 * c);
    localparam logic [ADDR_W-1:0] ADR_O = ADDR_W'(2 * c + 1);
    logic gain_we, offs_we;
    logic [GAIN_W-1:0] gain_q;
    logic [DATA_W-1:0] offs_q;

    always_comb begin
      gain_we = commit_i && (addr_i == ADR_G);
      offs_we = commit_i && (addr_i == ADR_O);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q <= GAIN_RST;
        offs_q <= OFFS_RST;
      end else if (soft_rst) begin
        gain_q <= GAIN_RST;
        offs_q <= OFFS_RST;
      end else begin
        if (gain_we) gain_q <= data_i[DATA_W-1 -: GAIN_W];
        if (offs_we) offs_q <= data_i;
      end
    end

    assign gain_o[c] = gain_q;
    assign offs_o[c] = offs_q;
  end

  // mode next value: self-clearing reset bit, config dropped on power-down exit
  always_comb begin
    mode_d          = data_i;
    mode_d[MB_SRST] = 1'b0;
    if (mode_q[MB_PD] && !data_i[MB_PD])
      mode_d[CFG_W-1:0] = '0;
    if (soft_rst)
      mode_d = MODE_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      test_q <= TEST_RST;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (soft_rst)     test_q <= TEST_RST;
      else if (test_we) test_q <= data_i;
    end
  end

  assign mode_o = mode_q;
  assign test_o = test_q;
endmodule

// File: rtl/shared_pin_reg_loader.sv
module shared_pin_reg_loader
  import slp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUS_W       = 8,
  parameter int LD_BIT      = 7,
  parameter int SD_BIT      = 6,
  parameter int SC_BIT      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [BUS_W-1:0] pix_data_i,
  input  logic [BUS_W-1:0] pad_in,
  output logic [BUS_W-1:0] pad_out,
  output logic             pad_oe,
  output logic [5:0]       gain_red,
  output logic [5:0]       gain_grn,
  output logic [5:0]       gain_blu,
  output logic [7:0]       offs_red,
  output logic [7:0]       offs_grn,
  output logic [7:0]       offs_blu,
  output logic [7:0]       mode_o,
  output logic [7:0]       test_o
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic                          commit_w;
  logic [FRAME_W-1:0]            word_w;
  logic [CNT_W-1:0]              bitcnt_w;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain_w;
  logic [NUM_CH-1:0][DATA_W-1:0] offs_w;

  slp_pad_mux #(.BUS_W(BUS_W)) u_pad (
    .sync_i   (sync_i),
    .pix_i    (pix_data_i),
    .pad_out_o(pad_out),
    .pad_oe_o (pad_oe)
  );

  slp_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .port_en (sync_i),
    .ld_pin  (pad_in[LD_BIT]),
    .sc_pin  (pad_in[SC_BIT]),
    .sd_pin  (pad_in[SD_BIT]),
    .commit_o(commit_w),
    .word_o  (word_w),
    .bitcnt_o(bitcnt_w)
  );

  slp_reg_bank u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .commit_i(commit_w),
    .addr_i  (word_w[FRAME_W-1 -: ADDR_W]),
    .data_i  (word_w[DATA_W-1:0]),
    .gain_o  (gain_w),
    .offs_o  (offs_w),
    .mode_o  (mode_o),
    .test_o  (test_o)
  );

  assign gain_red = gain_w[0];
  assign gain_grn = gain_w[1];
  assign gain_blu = gain_w[2];
  assign offs_red = offs_w[0];
  assign offs_grn = offs_w[1];
  assign offs_blu = offs_w[2];
endmodule

// File: rtl/slp_checker.sv
module slp_checker #(
  parameter int CNT_W   = 4,
  parameter int FRAME_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             pad_oe,
  input logic             commit,
  input logic [CNT_W-1:0] bitcnt,
  input logic [7:0]       mode_o,
  input logic [5:0]       gain_red,
  input logic [7:0]       offs_red,
  input logic [7:0]       test_o
);
  a_r1_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> !pad_oe);

  a_r4_commit_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (bitcnt == CNT_W'(FRAME_W)));

  a_r5_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= CNT_W'(FRAME_W));

  a_r7_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_o[6]);

  a_r8_pd_exit_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_o[7]) |-> (mode_o[1:0] == 2'b00));

  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(gain_red) && $stable(offs_red) && $stable(mode_o) && $stable(test_o)));
endmodule

bind shared_pin_reg_loader slp_checker #(.CNT_W(slp_pkg::CNT_W), .FRAME_W(slp_pkg::FRAME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .sync_i  (sync_i),
  .pad_oe  (pad_oe),
  .commit  (commit_w),
  .bitcnt  (bitcnt_w),
  .mode_o  (mode_o),
  .gain_red(gain_red),
  .offs_red(offs_red),
  .test_o  (test_o)
);

// File: tb/sim_shared_pin_reg_loader.sv
module sim_shared_pin_reg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic [7:0] pix = 8'h00;
  logic ld = 1'b1, sd = 1'b0, sc = 1'b0;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic pad_oe;
  logic [5:0] gain_red, gain_grn, gain_blu;
  logic [7:0] offs_red, offs_grn, offs_blu, mode_o, test_o;
  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign pad_in = {ld, sd, sc, 5'b00000};

  shared_pin_reg_loader u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pix_data_i(pix),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .gain_red(gain_red), .gain_grn(gain_grn), .gain_blu(gain_blu),
    .offs_red(offs_red), .offs_grn(offs_grn), .offs_blu(offs_blu),
    .mode_o(mode_o), .test_o(test_o)
  );

  // {addr[2:0], data[7:0], nclk[3:0], expected readback[7:0]}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 8'hA7, 4'd11, 8'hA4},   // R6 gain keeps bits 7..2
    {3'd1, 8'h5C, 4'd11, 8'h5C},   // R3
    {3'd2, 8'hFF, 4'd11, 8'hFC},   // R6
    {3'd3, 8'h13, 4'd9,  8'h40},   // R4 short frame
    {3'd4, 8'h30, 4'd14, 8'h30},   // R5 extra clocks
    {3'd5, 8'h81, 4'd11, 8'h81},   // R6
    {3'd7, 8'h5A, 4'd11, 8'h5A},   // R6
    {3'd6, 8'h2D, 4'd11, 8'h2D},   // R8
    {3'd6, 8'h8E, 4'd11, 8'h8E},   // R8 enter power-down
    {3'd6, 8'h17, 4'd11, 8'h14},   // R8 exit clears config
    {3'd6, 8'h17, 4'd11, 8'h17},   // R8 rewrite
    {3'd3, 8'h00, 4'd10, 8'h40}    // R4
  };

  function automatic logic [7:0] rd(input logic [2:0] a);
    case (a)
      3'd0: rd = {gain_red, 2'b00};
      3'd1: rd = offs_red;
      3'd2: rd = {gain_grn, 2'b00};
      3'd3: rd = offs_grn;
      3'd4: rd = {gain_blu, 2'b00};
      3'd5: rd = offs_blu;
      3'd6: rd = mode_o;
      default: rd = test_o;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] a, input logic [7:0] d, input int n, input bit drop);
    logic [10:0] w;
    w = {a, d};
    sync_i = 1'b1;
    wclk(4);
    ld = 1'b0;
    wclk(4);
    for (int i = 0; i < n; i++) begin
      sd = (i < 11) ? w[10 - i] : 1'b1;
      wclk(4);
      sc = 1'b1;
      wclk(4);
      sc = 1'b0;
      wclk(2);
    end
    wclk(4);
    if (drop) begin
      sync_i = 1'b0;
      wclk(4);
    end
    ld = 1'b1;
    wclk(8);
    sync_i = 1'b0;
    wclk(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(5);
    // R2 reset state
    for (int a = 0; a < 8; a++)
      chk("R2 reset value", rd(3'(a)), (a == 1 || a == 3 || a == 5) ? 8'h40 : 8'h00);

    // R1 pad ownership
    pix = 8'h3C;
    sync_i = 1'b0;
    wclk(1);
    chk("R1 oe when sync low", {7'd0, pad_oe}, 8'h01);
    chk("R1 pad follows pixel", pad_out, 8'h3C);
    sync_i = 1'b1;
    wclk(1);
    chk("R1 oe when sync high", {7'd0, pad_oe}, 8'h00);
    sync_i = 1'b0;
    wclk(1);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][22:20], VEC[i][19:12], int'(VEC[i][11:8]), 1'b0);
      chk($sformatf("R3/R4/R5/R6/R8 vector %0d", i), rd(VEC[i][22:20]), VEC[i][7:0]);
    end

    // R8 power-down left other registers alone
    chk("R8 red gain retained", {gain_red, 2'b00}, 8'hA4);
    chk("R8 test retained", test_o, 8'h5A);

    // R7 soft reset
    send(3'd6, 8'h45, 11, 1'b0);
    chk("R7 mode cleared", mode_o, 8'h00);
    chk("R7 red gain default", {gain_red, 2'b00}, 8'h00);
    chk("R7 blue offset default", offs_blu, 8'h40);
    chk("R7 test default", test_o, 8'h00);

    // R9 sync drop abandons frame
    send(3'd1, 8'h11, 11, 1'b1);
    chk("R9 aborted frame", offs_red, 8'h40);
    send(3'd1, 8'h11, 11, 1'b0);
    chk("R9 next frame works", offs_red, 8'h11);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule